// File: doc/BRIEF.md
# Indexed Absolute XOR Sequencer

This block steps an 8-bit processor datapath through one instruction: it XORs the accumulator with a memory byte. The address of that byte is a 16-bit base taken from the instruction stream plus the 8-bit X index. The block runs continuously from a reset address. Every byte it fetches as an opcode is executed as this instruction, so a test program is a plain run of three-byte instructions: opcode, address low byte, address high byte.

All address arithmetic goes through one shared 8-bit ALU. The low sum (base low byte plus X) is formed while the high base byte is being read. The next cycle issues a read from the high byte and that sum without waiting for the carry, and in the same cycle the ALU computes the high byte plus one. When the add carried, that read is thrown away: the upper address latch takes the incremented page and the read is repeated. Otherwise the incremented page is discarded. The XOR result is written to the accumulator one instruction step late, overlapping the next instruction's low-byte fetch.

The X register is loaded from a port. The accumulator and the zero and negative flags are visible as outputs.

Top module: `idxeor_seq`

## Requirements
- R1: While reset is asserted, memAddr equals the RESET_PC parameter, syncOut is 1, and accOut, flagZ and flagN are all 0.
- R2: The first cycle of every instruction is an opcode fetch. In that cycle syncOut is 1 and memAddr is the program counter. The opcode byte's value has no effect on the sequence.
- R3: The next two cycles read at PC+1 (address low byte) and PC+2 (address high byte). The program counter counts as a 16-bit value, so the upper byte advances when the lower byte wraps from 0xFF to 0x00.
- R4: The fourth cycle always reads at {high, (low + X) mod 256}, including when low + X exceeds 255.
- R5: When low + X exceeds 255, a fifth cycle reads at {(high + 1) mod 256, (low + X) mod 256} and the instruction takes 5 cycles. Otherwise it takes 4 cycles. The next opcode fetch is at PC+3 either way.
- R6: The accumulator becomes the old accumulator XOR the byte from the last read of the instruction. The new value is visible from the third cycle of the following instruction. At no other time does the accumulator change.
- R7: flagZ is set to (result == 0) and flagN to bit 7 of the result at the same edge as the accumulator write. The flags hold their values otherwise.
- R8: X resets to 0. On an edge with xLoad high, X takes xLoadVal, and X is then used by later index additions.
- R9: memRd is 1 in every cycle out of reset, because each cycle of the sequence is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| xLoad | input | 1 | Load the X index register on this edge |
| xLoadVal | input | 8 | Value for the X index register |
| memRdData | input | 8 | Read data, valid for memAddr within the same cycle |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read strobe |
| syncOut | output | 1 | High in an opcode fetch cycle |
| accOut | output | 8 | Accumulator |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |

## Verification
A wrong program counter, a stale address latch or a lost carry shows up on memAddr in the very cycle the bad value is used. A wrong carry decision also shows on syncOut one cycle later, because the next opcode fetch arrives one cycle early or late. A corrupted data latch or ALU result stays hidden until the accumulator write, two cycles into the following instruction, where accOut and the flags disagree with the reference.

// File: rtl/idxeor_pkg.sv
package idxeor_pkg;

  typedef enum logic [2:0] {
    HI_PC,
    HI_LATCH,
    HI_ZERO,
    HI_ONE,
    HI_FF
  } hiSel_e;

  typedef enum logic {
    LO_PC,
    LO_LATCH
  } loSel_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_INC,
    ALU_XOR
  } aluOp_e;

  typedef enum logic [1:0] {
    LAT_HOLD,
    LAT_DATA,
    LAT_ALU
  } latSrc_e;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_LO,
    ST_HI,
    ST_SPEC,
    ST_FIX
  } seqState_e;

  typedef struct packed {
    hiSel_e  hiSel;
    loSel_e  loSel;
    logic    pcInc;
    logic    dlLoad;
    aluOp_e  aluOp;
    latSrc_e adlSrc;
    latSrc_e adhSrc;
    logic    accLoad;
  } ctrl_t;

endpackage

// File: rtl/idxeor_ctrl.sv
module idxeor_ctrl
  import idxeor_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  carry,
  output ctrl_t ctrl,
  output logic  rdStrobe,
  output logic  syncStrobe
);

  seqState_e state;
  seqState_e stateNext;
  logic      pending;
  logic      pendingNext;

  always_comb begin
    ctrl        = '0;
    ctrl.hiSel  = HI_PC;
    ctrl.loSel  = LO_PC;
    ctrl.aluOp  = ALU_PASS;
    ctrl.adlSrc = LAT_HOLD;
    ctrl.adhSrc = LAT_HOLD;
    rdStrobe    = 1'b1;
    syncStrobe  = 1'b0;
    stateNext   = state;
    pendingNext = pending;
    case (state)
      ST_OPC: begin
        syncStrobe = 1'b1;
        ctrl.pcInc = 1'b1;
        ctrl.aluOp = ALU_XOR;
        stateNext  = ST_LO;
      end
      ST_LO: begin
        ctrl.pcInc   = 1'b1;
        ctrl.dlLoad  = 1'b1;
        ctrl.accLoad = pending;
        pendingNext  = 1'b0;
        stateNext    = ST_HI;
      end
      ST_HI: begin
        ctrl.pcInc  = 1'b1;
        ctrl.dlLoad = 1'b1;
        ctrl.aluOp  = ALU_ADD;
        ctrl.adlSrc = LAT_ALU;
        ctrl.adhSrc = LAT_DATA;
        stateNext   = ST_SPEC;
      end
      ST_SPEC: begin
        ctrl.hiSel  = HI_LATCH;
        ctrl.loSel  = LO_LATCH;
        ctrl.dlLoad = 1'b1;
        ctrl.aluOp  = ALU_INC;
        if (carry) begin
          ctrl.adhSrc = LAT_ALU;
          stateNext   = ST_FIX;
        end else begin
          pendingNext = 1'b1;
          stateNext   = ST_OPC;
        end
      end
      ST_FIX: begin
        ctrl.hiSel  = HI_LATCH;
        ctrl.loSel  = LO_LATCH;
        ctrl.dlLoad = 1'b1;
        pendingNext = 1'b1;
        stateNext   = ST_OPC;
      end
      default: stateNext = ST_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
    end
  end

  AST_HI_THEN_SPEC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HI) |=> (state == ST_SPEC)); // R4
  AST_CARRY_FIX: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPEC && carry) |=> (state == ST_FIX)); // R5
  AST_NOCARRY_OPC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SPEC && !carry) |=> (state == ST_OPC)); // R5
  AST_FIX_OPC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIX) |=> (state == ST_OPC)); // R5

endmodule

// File: rtl/idxeor_datapath.sv
module idxeor_datapath
  import idxeor_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [2*DATA_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic                xLoad,
  input  logic [DATA_W-1:0]   xLoadVal,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] addr,
  output logic                carry,
  output logic [DATA_W-1:0]   accOut,
  output logic                zeroFlag,
  output logic                negFlag
);

  localparam logic [DATA_W:0]   ONE_W  = 1;
  localparam logic [DATA_W-1:0] ONE_B  = 1;
  localparam logic [DATA_W-1:0] ALL_B  = '1;

  logic [DATA_W-1:0] pcLo, pcHi;
  logic [DATA_W-1:0] adl, adh;
  logic [DATA_W-1:0] dataLatch;
  logic [DATA_W-1:0] aluReg;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] xReg;
  logic              carryReg;
  logic [DATA_W:0]   aluWide;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] addrHi, addrLo;

  always_comb begin
    case (ctrl.aluOp)
      ALU_ADD: aluWide = {1'b0, dataLatch} + {1'b0, xReg};
      ALU_INC: aluWide = {1'b0, dataLatch} + ONE_W;
      ALU_XOR: aluWide = {1'b0, acc ^ dataLatch};
      default: aluWide = {1'b0, aluReg};
    endcase
  end
  assign aluRes = aluWide[DATA_W-1:0];

  always_comb begin
    case (ctrl.hiSel)
      HI_PC:    addrHi = pcHi;
      HI_LATCH: addrHi = adh;
      HI_ONE:   addrHi = ONE_B;
      HI_FF:    addrHi = ALL_B;
      default:  addrHi = '0;
    endcase
    addrLo = (ctrl.loSel == LO_LATCH) ? adl : pcLo;
  end
  assign addr = {addrHi, addrLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLo      <= RESET_PC[DATA_W-1:0];
      pcHi      <= RESET_PC[2*DATA_W-1:DATA_W];
      adl       <= '0;
      adh       <= '0;
      dataLatch <= '0;
      aluReg    <= '0;
      acc       <= '0;
      xReg      <= '0;
      carryReg  <= 1'b0;
      zeroFlag  <= 1'b0;
      negFlag   <= 1'b0;
    end else begin
      aluReg <= aluRes;
      if (ctrl.aluOp == ALU_ADD) carryReg <= aluWide[DATA_W];
      if (ctrl.pcInc) begin
        pcLo <= pcLo + ONE_B;
        if (pcLo == ALL_B) pcHi <= pcHi + ONE_B;
      end
      if (ctrl.dlLoad) dataLatch <= rdData;
      case (ctrl.adlSrc)
        LAT_DATA: adl <= rdData;
        LAT_ALU:  adl <= aluRes;
        default:  adl <= adl;
      endcase
      case (ctrl.adhSrc)
        LAT_DATA: adh <= rdData;
        LAT_ALU:  adh <= aluRes;
        default:  adh <= adh;
      endcase
      if (ctrl.accLoad) begin
        acc      <= aluReg;
        zeroFlag <= (aluReg == '0);
        negFlag  <= aluReg[DATA_W-1];
      end
      if (xLoad) xReg <= xLoadVal;
    end
  end

  assign carry  = carryReg;
  assign accOut = acc;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.accLoad |=> $stable(acc)); // R6
  AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accLoad |=> (zeroFlag == (acc == '0)) && (negFlag == acc[DATA_W-1])); // R7
  AST_PAGE_FIX: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.adhSrc == LAT_ALU) |=> (adh == $past(dataLatch) + ONE_B)); // R5
  AST_X_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    xLoad |=> (xReg == $past(xLoadVal))); // R8

endmodule

// File: rtl/idxeor_seq.sv
module idxeor_seq
  import idxeor_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xLoad,
  input  logic [7:0]  xLoadVal,
  input  logic [7:0]  memRdData,
  output logic [15:0] memAddr,
  output logic        memRd,
  output logic        syncOut,
  output logic [7:0]  accOut,
  output logic        flagZ,
  output logic        flagN
);

  ctrl_t ctrl;
  logic  carry;

  idxeor_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .carry     (carry),
    .ctrl      (ctrl),
    .rdStrobe  (memRd),
    .syncStrobe(syncOut)
  );

  idxeor_datapath #(
    .DATA_W  (DATA_W),
    .RESET_PC(RESET_PC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .xLoad   (xLoad),
    .xLoadVal(xLoadVal),
    .rdData  (memRdData),
    .addr    (memAddr),
    .carry   (carry),
    .accOut  (accOut),
    .zeroFlag(flagZ),
    .negFlag (flagN)
  );

  AST_LOW_BYTE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |=> (memAddr == $past(memAddr) + 16'd1)); // R3

endmodule

// File: tb/idxeor_seq_tb.sv
module idxeor_seq_tb;

  localparam logic [15:0] PROG_BASE = 16'h01FB;
  localparam int          NI        = 12;
  localparam int          PLEN      = NI * 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xLoad = 1'b0;
  logic [7:0]  xLoadVal = '0;
  logic [7:0]  memRdData;
  logic [15:0] memAddr;
  logic        memRd, syncOut, flagZ, flagN;
  logic [7:0]  accOut;

  int total = 0;
  int fails = 0;

  logic [7:0] prog [PLEN];

  logic [15:0] qAddr[$];
  bit          qSync[$];
  logic [7:0]  qAcc[$];
  bit          qZ[$];
  bit          qN[$];
  string       qTag[$];

  logic [7:0] mAcc;
  bit         mZ, mN;

  always #4 clk = ~clk;

  idxeor_seq #(.DATA_W(8), .RESET_PC(PROG_BASE)) u_dut (
    .clk(clk), .rstN(rstN), .xLoad(xLoad), .xLoadVal(xLoadVal),
    .memRdData(memRdData), .memAddr(memAddr), .memRd(memRd),
    .syncOut(syncOut), .accOut(accOut), .flagZ(flagZ), .flagN(flagN)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    logic [15:0] off;
    off = a - PROG_BASE;
    if (int'(off) < PLEN) return prog[int'(off)];
    return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign memRdData = memByte(memAddr);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic pushE(input logic [15:0] a, input bit s, input string tag);
    qAddr.push_back(a);
    qSync.push_back(s);
    qAcc.push_back(mAcc);
    qZ.push_back(mZ);
    qN.push_back(mN);
    qTag.push_back(tag);
  endtask

  task automatic buildProg(input int ph, input logic [7:0] x);
    for (int i = 0; i < NI; i++) begin
      logic [7:0] lo, hi;
      if (i < 2) begin
        lo = 8'h20; hi = 8'h57;
      end else if (i == 2) begin
        lo = 8'hFF; hi = 8'hFF;
      end else if (i == 3) begin
        lo = 8'(9'h100 - {1'b0, x}); hi = 8'h80;
      end else begin
        lo = 8'(i * 53 + ph * 29); hi = 8'(8'h30 + i * 17);
      end
      prog[3*i]   = 8'(8'h5D + i * 7 + ph);
      prog[3*i+1] = lo;
      prog[3*i+2] = hi;
    end
  endtask

  task automatic buildExpect(input logic [7:0] x);
    logic [15:0] pc;
    logic [7:0]  pendVal;
    bit          pendOn;
    qAddr.delete(); qSync.delete(); qAcc.delete();
    qZ.delete(); qN.delete(); qTag.delete();
    pc = PROG_BASE; mAcc = 0; mZ = 0; mN = 0; pendOn = 0; pendVal = 0;
    for (int i = 0; i < NI; i++) begin
      logic [7:0]  lo, hi;
      logic [15:0] ea;
      int          sum;
      pushE(pc, 1'b1, "R2");
      pushE(pc + 16'd1, 1'b0, "R3");
      if (pendOn) begin
        mAcc = pendVal; mZ = (pendVal == 0); mN = pendVal[7]; pendOn = 0;
      end
      pushE(pc + 16'd2, 1'b0, "R3");
      lo  = memByte(pc + 16'd1);
      hi  = memByte(pc + 16'd2);
      sum = int'(lo) + int'(x);
      ea  = {hi, 8'(sum)};
      pushE(ea, 1'b0, "R4");
      if (sum > 255) begin
        ea = {8'(hi + 8'd1), 8'(sum)};
        pushE(ea, 1'b0, "R5");
      end
      pendVal = mAcc ^ memByte(ea);
      pendOn  = 1;
      pc      = pc + 16'd3;
    end
  endtask

  task automatic runPhase(input int ph, input logic [7:0] x, input bit doLoad);
    logic [7:0] xEff;
    xEff = doLoad ? x : 8'h00;
    buildProg(ph, x);
    buildExpect(xEff);
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset addr", 32'(memAddr), 32'(PROG_BASE));
    check("R1", "reset sync", 32'(syncOut), 32'd1);
    check("R1", "reset acc", 32'(accOut), 32'd0);
    check("R1", "reset Z", 32'(flagZ), 32'd0);
    check("R1", "reset N", 32'(flagN), 32'd0);
    rstN     = 1'b1;
    xLoad    = doLoad;
    xLoadVal = x;
    for (int k = 0; k < qAddr.size(); k++) begin
      check(qTag[k], "memAddr", 32'(memAddr), 32'(qAddr[k]));
      check("R5", "syncOut", 32'(syncOut), 32'(qSync[k]));
      check("R9", "memRd", 32'(memRd), 32'd1);
      check("R6", "accOut", 32'(accOut), 32'(qAcc[k]));
      check("R7", "flagZ", 32'(flagZ), 32'(qZ[k]));
      check("R7", "flagN", 32'(flagN), 32'(qN[k]));
      @(negedge clk);
      xLoad = 1'b0;
    end
  endtask

  initial begin
    runPhase(0, 8'h10, 1'b1);   // R8 loaded X, page-wrap carry from 0xFF page
    runPhase(1, 8'hC3, 1'b1);   // R8 large X, many carries
    runPhase(2, 8'h77, 1'b0);   // R8 X left at its reset value 0
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule